// File: doc/BRIEF.md
# Two-Wire Block-Read Register Slave

This block is a slave on a two-wire management bus (open-drain clock and data). It serves register reads from a master using a block-read sequence. The master first sends a write-direction address byte carrying the slave's 7-bit address, followed by an 8-bit register index. It then issues a repeated start and a read-direction address byte. After that, the slave sends back a length byte and then that many data bytes. The master acknowledges each byte it wants continued and ends with a NACK and a stop.

The length comes from an external length table, looked up by the latched register index. The data bytes come from an external register file, read at consecutive addresses beginning at that same index. The slave never drives the clock. It only pulls the data line low, and only while the clock is low. An enable input gates the whole interface. A busy input, raised while some external configuration load is running, keeps the slave fully silent so that any master access times out.

Both bus inputs pass through a two-stage synchroniser and a stability filter before start, stop and clock-edge detection. A start or stop that arrives in the middle of a byte abandons the transfer and resynchronises the slave.

Top module: `smb_blkread_slave`

## Requirements
- R1: For a transaction addressed to the slave's own address, the slave ACKs (data held low in the acknowledge slot) the write-direction address byte (LSB 0), the register-index byte and the read-direction address byte (LSB 1).
- R2: The first byte returned after the read-direction address is the length value `blk_len` for the latched index `reg_sel`, sent MSB first.
- R3: Data bytes follow the length byte MSB first, taken from `rf_data` at `rf_addr` = index, index+1, ... (modulo 256), one byte per master ACK, and never more than the length value.
- R4: If the read-direction address after the repeated start does not match, the slave leaves data released in that acknowledge slot (NACK) and drives nothing until the next stop or start.
- R5: A write-direction address byte that does not match gets no ACK, and the rest of the transfer is ignored.
- R6: While `enable` is 0 the slave never drives the data line and ignores all traffic.
- R7: While `busy` is 1 the slave drives no acknowledge or data bits.
- R8: When the master NACKs a data byte, the slave releases the data line and drives nothing for further clocks until a stop or start.
- R9: After reset, and after any stop, the slave is idle with data released. A stop or start in the middle of a byte aborts the transfer, and the next full transaction completes correctly.
- R10: The slave begins pulling the data line low only while the filtered clock is low.
- R11: A clock pulse shorter than the filter length (`GLITCH_LEN` cycles) is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global interface enable; 0 keeps the slave silent |
| busy | input | 1 | External load in progress; slave stays silent |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_sel | output | 8 | Latched register index, address into the length table |
| blk_len | input | 8 | Length byte for `reg_sel` |
| rf_addr | output | 8 | Register-file read address |
| rf_data | input | 8 | Register-file read data for `rf_addr` |

## Verification
In a single cycle, the state machine can see both a filtered clock edge, which is normally a bit-shift or byte-boundary action, and a bus condition or gating input that must take precedence. The bench provokes this by issuing stop and repeated-start conditions after only a few bits of a byte. It also inserts a one-cycle clock pulse during a low phase and runs whole transactions with `enable` low or `busy` high. Each case is judged at the pins: the ACK bits and returned bytes must match bench-computed values, the cycle counter of data-line drive must stay at zero while gated, and a normal transaction must complete correctly right after an abort.

// File: rtl/smb_blkread_pkg.sv
package smb_blkread_pkg;

    localparam int unsigned BITS_PER_BYTE = 8;
    localparam int unsigned BIT_CNT_W     = $clog2(BITS_PER_BYTE + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR1,
        ST_ACK1,
        ST_REG,
        ST_ACK2,
        ST_WAIT,
        ST_ADR2,
        ST_ACK3,
        ST_TX,
        ST_MACK,
        ST_IGN
    } smb_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] rx_byte,
                                      input logic [6:0] own,
                                      input logic       rd);
        return (rx_byte[7:1] == own) && (rx_byte[0] == rd);
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_LEN  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(GLITCH_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          stab_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= 1'b1;
            stab_q <= '0;
        end else if (synced == dout) begin
            stab_q <= '0;
        end else if (stab_q == CW'(GLITCH_LEN - 1)) begin
            dout   <= synced;
            stab_q <= '0;
        end else begin
            stab_q <= stab_q + 1'b1;
        end
    end

    // R11
    filt_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> (synced == dout));

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
    import smb_blkread_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_p & scl_f & sda_p & ~sda_f;
        ev.stop  = scl_p & scl_f & ~sda_p & sda_f;
        ev.rise  = ~scl_p & scl_f;
        ev.fall  = scl_p & ~scl_f;
    end

endmodule

// File: rtl/smb_blk_fsm.sv
module smb_blk_fsm
    import smb_blkread_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h2A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       busy,
    input  bus_ev_t    ev,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] blk_len,
    input  logic [7:0] rf_data,
    output logic [7:0] rf_addr,
    output logic [7:0] reg_sel,
    output logic       sda_oe
);
    smb_state_e           st;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [7:0]           sh;
    logic [7:0]           ptr;
    logic [7:0]           left;
    logic                 m_ack;

    assign rf_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            sh      <= '0;
            reg_sel <= '0;
            ptr     <= '0;
            left    <= '0;
            m_ack   <= 1'b0;
        end else if (!enable || busy) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else if (ev.stop) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else if (ev.start) begin
            st      <= (st == ST_WAIT) ? ST_ADR2 : ST_ADR1;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else begin
            case (st)
                ST_ADR1, ST_REG, ST_ADR2: begin
                    if (ev.rise) begin
                        sh      <= {sh[6:0], sda_f};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.fall && bit_cnt == BIT_CNT_W'(BITS_PER_BYTE)) begin
                        bit_cnt <= '0;
                        if (st == ST_ADR1) begin
                            if (addr_hit(sh, OWN_ADDR, 1'b0)) begin
                                st     <= ST_ACK1;
                                sda_oe <= 1'b1;
                            end else begin
                                st <= ST_IGN;
                            end
                        end else if (st == ST_REG) begin
                            reg_sel <= sh;
                            st      <= ST_ACK2;
                            sda_oe  <= 1'b1;
                        end else begin
                            if (addr_hit(sh, OWN_ADDR, 1'b1)) begin
                                st     <= ST_ACK3;
                                sda_oe <= 1'b1;
                            end else begin
                                st <= ST_IGN;
                            end
                        end
                    end
                end
                ST_ACK1: if (ev.fall) begin
                    sda_oe <= 1'b0;
                    st     <= ST_REG;
                end
                ST_ACK2: if (ev.fall) begin
                    sda_oe <= 1'b0;
                    st     <= ST_WAIT;
                end
                ST_ACK3: if (ev.fall) begin
                    sh      <= blk_len;
                    sda_oe  <= ~blk_len[7];
                    left    <= blk_len;
                    ptr     <= reg_sel;
                    bit_cnt <= '0;
                    st      <= ST_TX;
                end
                ST_TX: if (ev.fall) begin
                    if (bit_cnt == BIT_CNT_W'(BITS_PER_BYTE - 1)) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        st      <= ST_MACK;
                    end else begin
                        sda_oe  <= ~sh[6];
                        sh      <= {sh[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        m_ack <= ~sda_f;
                    end else if (ev.fall) begin
                        if (m_ack && left != 8'd0) begin
                            sh      <= rf_data;
                            sda_oe  <= ~rf_data[7];
                            ptr     <= ptr + 1'b1;
                            left    <= left - 1'b1;
                            bit_cnt <= '0;
                            st      <= ST_TX;
                        end else begin
                            st <= ST_IGN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    enable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !sda_oe);

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !sda_oe);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st == ST_IDLE) && !sda_oe);

    // R10
    drive_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX) && $past(st == ST_MACK) |-> $past(left) != 8'd0);

    // R1
    bit_range_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= BIT_CNT_W'(BITS_PER_BYTE));

endmodule

// File: rtl/smb_blkread_slave.sv
module smb_blkread_slave
    import smb_blkread_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2,
    parameter int         GLITCH_LEN  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       busy,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_sel,
    input  logic [7:0] blk_len,
    output logic [7:0] rf_addr,
    input  logic [7:0] rf_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] filt;
    bus_ev_t            ev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        smb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .GLITCH_LEN (GLITCH_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .dout(filt[g])
        );
    end

    smb_cond_detect u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_f(filt[1]),
        .sda_f(filt[0]),
        .ev   (ev)
    );

    smb_blk_fsm #(
        .OWN_ADDR(OWN_ADDR)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .busy   (busy),
        .ev     (ev),
        .scl_f  (filt[1]),
        .sda_f  (filt[0]),
        .blk_len(blk_len),
        .rf_data(rf_data),
        .rf_addr(rf_addr),
        .reg_sel(reg_sel),
        .sda_oe (sda_oe)
    );

endmodule

// File: tb/smb_blkread_slave_test.sv
module smb_blkread_slave_test;

    localparam logic [6:0] SA = 7'h2A;
    localparam int         Q  = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       busy = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_sel, blk_len, rf_addr, rf_data;
    logic       sda_line;

    int total = 0;
    int bad   = 0;
    int oe_cnt = 0;

    function automatic logic [7:0] exp_len(input logic [7:0] r);
        return r % 8'd5;
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] a);
        return (a * 8'd7) ^ 8'h5A;
    endfunction

    assign sda_line = m_sda & ~sda_oe;
    assign blk_len  = exp_len(reg_sel);
    assign rf_data  = exp_data(rf_addr);

    always #4 clk = ~clk;

    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    smb_blkread_slave uut (
        .clk(clk), .rst(rst), .enable(enable), .busy(busy),
        .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_sel(reg_sel), .blk_len(blk_len),
        .rf_addr(rf_addr), .rf_data(rf_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        m_sda = b; wq(Q);
        m_scl = 1'b1; wq(Q);
        r = sda_line; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bstart();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic brstart();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(v[i], r);
        xbit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv(output logic [7:0] v, input logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b1, r);
            v[i] = r;
        end
        xbit(nack, r);
    endtask

    task automatic txn(input logic [6:0] a1, input logic [7:0] rg, input logic [6:0] a2,
                       input bit on, input string offtag, input bit glitch,
                       input bit early, input bit nostart);
        logic       ack;
        logic [7:0] v;
        int         n;
        bit         e1, e3, last;
        if (!nostart) bstart();
        if (glitch) begin
            wq(3); m_scl = 1'b1; wq(1); m_scl = 1'b0; wq(3);
        end
        send({a1, 1'b0}, ack);
        e1 = on && (a1 == SA);
        chk(ack == e1, glitch ? "R11" : (e1 ? "R1" : (on ? "R5" : offtag)), ack, e1);
        if (!e1) begin
            recv(v, 1'b1);
            chk(v == 8'hFF, on ? "R5" : offtag, v, 8'hFF);
            bstop();
            return;
        end
        send(rg, ack);
        chk(ack == 1'b1, "R1", ack, 1);
        brstart();
        send({a2, 1'b1}, ack);
        e3 = (a2 == SA);
        chk(ack == e3, e3 ? "R1" : "R4", ack, e3);
        if (!e3) begin
            recv(v, 1'b1);
            chk(v == 8'hFF, "R4", v, 8'hFF);
            bstop();
            return;
        end
        n = int'(exp_len(rg));
        recv(v, n == 0);
        chk(v == exp_len(rg), "R2", v, exp_len(rg));
        for (int i = 0; i < n; i++) begin
            last = (i == n - 1) || (early && i == 0);
            recv(v, last);
            chk(v == exp_data(rg + 8'(i)), "R3", v, exp_data(rg + 8'(i)));
            if (last && i < n - 1) begin
                recv(v, 1'b1);
                chk(v == 8'hFF, "R8", v, 8'hFF);
                break;
            end
        end
        bstop();
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int         base;
        logic       r;
        logic [7:0] rg;
        logic [6:0] a1, a2;
        void'($urandom(32'd20240611));
        wq(5);
        rst = 1'b0;
        wq(2);
        chk(sda_oe == 1'b0 && reg_sel == 8'h00, "R9", {reg_sel, sda_oe}, 0);
        enable = 1'b1;
        wq(5);

        txn(SA, 8'h04, SA, 1, "", 0, 0, 0);      // R2 R3 length 4
        txn(SA, 8'h05, SA, 1, "", 0, 0, 0);      // R2 length 0
        txn(SA, 8'hFE, SA, 1, "", 0, 0, 0);      // R3 address wrap
        txn(SA, 8'h13, SA ^ 7'h01, 1, "", 0, 0, 0); // R4
        txn(SA ^ 7'h40, 8'h13, SA, 1, "", 0, 0, 0); // R5
        txn(SA, 8'h03, SA, 1, "", 0, 1, 0);      // R8 early nack
        txn(SA, 8'h09, SA, 1, "", 1, 0, 0);      // R11 short clock pulse

        enable = 1'b0; wq(5); base = oe_cnt;
        txn(SA, 8'h04, SA, 0, "R6", 0, 0, 0);
        chk(oe_cnt == base, "R6", oe_cnt - base, 0);
        enable = 1'b1; wq(5);

        busy = 1'b1; wq(5); base = oe_cnt;
        txn(SA, 8'h04, SA, 0, "R7", 0, 0, 0);
        chk(oe_cnt == base, "R7", oe_cnt - base, 0);
        busy = 1'b0; wq(5);

        // R9: stop in the middle of an address byte
        bstart();
        xbit(1'b0, r); xbit(1'b1, r); xbit(1'b0, r);
        bstop();
        chk(sda_oe == 1'b0, "R9", sda_oe, 0);
        txn(SA, 8'h02, SA, 1, "", 0, 0, 0);

        // R9: start in the middle of a register-index byte
        bstart();
        send({SA, 1'b0}, r);
        xbit(1'b1, r); xbit(1'b1, r); xbit(1'b0, r);
        brstart();
        txn(SA, 8'h07, SA, 1, "", 0, 0, 1);

        for (int k = 0; k < 18; k++) begin
            rg = 8'($urandom);
            a1 = ($urandom % 6 == 0) ? SA ^ 7'(($urandom % 127) + 1) : SA;
            a2 = ($urandom % 6 == 0) ? SA ^ 7'(($urandom % 127) + 1) : SA;
            txn(a1, rg, a2, 1, "", 0, ($urandom % 4 == 0), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule